// File: doc/BRIEF.md
# Turbo Decoder Half-Iteration Sequencer

This block sequences the iterative passes of a turbo decoder that shares a single soft-in/soft-out engine between natural-order and interleaved-order half-iterations. A start pulse opens a block. The sequencer then tells the engine which order to use for each pass and counts the completed passes. It watches the stream of soft outputs to decide when decoding can stop early. It enforces a programmed minimum and maximum number of passes.

Once decoding stops, the sequencer runs a continuous write of the decoded block into an external output RAM. It steps an index that the surrounding logic uses to replay the final soft outputs and to compute interleaved addresses. It forms each hard bit from the sign of the replayed soft value. It picks the natural or the interleaved address according to the parity of the final pass count. One cycle after the last write, it publishes the pass count and a one-cycle early-termination pulse.

The decoding arithmetic and the interleaved address computation stay outside this block. They reach the sequencer only through `softVal` and `ilvAddr`.

Top module: `turbo_iter_seq`

## Requirements
- R1: After reset, `busy`=0, `wrCsN`=1, `halfDone`=0, `etPass`=0 and `ilvOrder`=0.
- R2: A `startPulse` seen while `busy`=0 raises `busy` from the next cycle onward. `blkLen` is captured at that moment. A `startPulse` seen while `busy`=1 has no effect on the block in progress.
- R3: During pass n of a block (n counted from 1), `ilvOrder`=0 (natural order) when n is odd and `ilvOrder`=1 (interleaved order) when n is even.
- R4: The block never stops on the threshold test before `minHalf` passes have completed.
- R5: The block always stops when the completed pass count reaches `maxHalf`. This holds even when `maxHalf` < `minHalf`. At least one pass always runs, so `maxHalf`=0 behaves like 1.
- R6: The threshold test passes for a pass only if every `softValid` value of that pass has a magnitude strictly greater than `etThresh`. This includes a value presented in the same cycle as `passDone`. The most negative code -2^(SW-1) has magnitude 2^(SW-1). The test is applied only on `passDone`, and it is reset at the start of every pass.
- R7: The write phase starts in the cycle after the deciding `passDone`. `wrCsN` is 0 for exactly `blkLen` consecutive cycles, and `rdIdx` counts 0 to `blkLen`-1 during those cycles.
- R8: During the write, `wrAddr` equals `rdIdx` if the final pass count is odd and equals `ilvAddr` if it is even.
- R9: During the write, `wrBit` equals bit SW-1 (the sign bit) of the two's-complement `softVal` in the same cycle.
- R10: In the cycle after the last write, `busy`=0 and `halfDone` holds the pass count. In that same cycle `etPass` is 1 for exactly one cycle, and only if the block stopped on the threshold test with the count below `maxHalf`. `halfDone` then holds until the next block finishes.
- R11: `passDone` and `softValid` seen while no pass is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Start decoding a block (one cycle) |
| passDone | input | 1 | Engine finished the current half-iteration |
| softValid | input | 1 | `softVal` carries a soft output of the current pass |
| softVal | input | SW (8) | Two's-complement soft output; replayed value during the write |
| blkLen | input | AW (15) | Block length in bits, at least 1 |
| minHalf | input | CW (5) | Minimum number of half-iterations |
| maxHalf | input | CW (5) | Maximum number of half-iterations |
| etThresh | input | SW-1 (7) | Early-termination magnitude threshold |
| ilvAddr | input | AW (15) | Interleaved address of `rdIdx`, from the external generator |
| busy | output | 1 | Block in progress |
| ilvOrder | output | 1 | Current pass uses interleaved order |
| rdIdx | output | AW (15) | Write-phase index for replay and address mapping |
| wrCsN | output | 1 | Output RAM chip select, active low |
| wrAddr | output | AW (15) | Output RAM write address |
| wrBit | output | 1 | Decoded hard bit |
| halfDone | output | CW (5) | Half-iterations executed on the last block |
| etPass | output | 1 | Last block ended on the threshold test |

## Verification
The soft streams rise in magnitude from pass to pass. Each scenario therefore has a known first pass that clears the threshold. The scenarios are:

- A free stop at an odd count.
- A stop held back by the minimum to an even count.
- A threshold too high to clear, so the maximum caps the count.
- A maximum below the minimum.
- A zero maximum.

Together these separate the early-termination stop from the maximum stop, and natural-order writes from interleaved-order writes. One stream places a sub-threshold value in the same cycle as the pass-done strobe. It distinguishes a test that includes that final value from one that misses it. Another stream is made only of the most negative code, which exposes a magnitude computation that overflows. Stray start and pass-done strobes are injected while busy and while idle. They show whether the block ignores them.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic accept;      // block accepted, capture length
    logic passStart;   // a pass begins next cycle, re-arm the threshold flag
    logic writeStart;  // decoding stopped, write phase begins next cycle
    logic endEven;     // final pass count is even
    logic etStop;      // stop was caused by the threshold test
    logic writing;     // this cycle is a write cycle
    logic finish;      // this cycle is the last write cycle
  } seqStrobe_t;

endpackage

// File: rtl/tis_ctrl.sv
module tis_ctrl
  import tis_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          passDone,
  input  logic          aboveNow,
  input  logic          lastIdx,
  input  logic [CW-1:0] minHalf,
  input  logic [CW-1:0] maxHalf,
  output seqStrobe_t    strobe,
  output logic [CW-1:0] halfCnt,
  output logic          busy,
  output logic          ilvOrder
);

  seqState_t     state, stateNext;
  logic [CW-1:0] nextCnt;
  logic          hitMax;
  logic          etOk;

  assign nextCnt = halfCnt + 1'b1;
  // maximum is tested first, so it governs when below the minimum
  assign hitMax  = nextCnt >= maxHalf;
  assign etOk    = (nextCnt >= minHalf) && aboveNow;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.accept    = 1'b1;
          strobe.passStart = 1'b1;
          stateNext        = ST_PASS;
        end
      end
      ST_PASS: begin
        if (passDone) begin
          if (hitMax || etOk) begin
            strobe.writeStart = 1'b1;
            strobe.endEven    = ~nextCnt[0];
            strobe.etStop     = ~hitMax;
            stateNext         = ST_WRITE;
          end else begin
            strobe.passStart = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        strobe.writing = 1'b1;
        if (lastIdx) begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.accept) begin
        halfCnt <= '0;
      end else if (state == ST_PASS && passDone) begin
        halfCnt <= nextCnt;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign ilvOrder = (state == ST_PASS) && halfCnt[0];

endmodule

// File: rtl/tis_dp.sv
module tis_dp
  import tis_pkg::*;
#(
  parameter int SW = 8,
  parameter int AW = 15,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic          softValid,
  input  logic [SW-1:0] softVal,
  input  logic [SW-2:0] etThresh,
  input  logic [AW-1:0] blkLen,
  input  logic [AW-1:0] ilvAddr,
  input  logic [CW-1:0] halfCnt,
  output logic          aboveNow,
  output logic          lastIdx,
  output logic [AW-1:0] rdIdx,
  output logic          wrCsN,
  output logic [AW-1:0] wrAddr,
  output logic          wrBit,
  output logic [CW-1:0] halfDone,
  output logic          etPass
);

  localparam int TW = SW - 1;

  logic [SW-1:0] mag;
  logic          beyond;
  logic          allAbove;
  logic [AW-1:0] lenQ;
  logic [AW-1:0] idx;
  logic          endEvenQ;
  logic          etPendQ;

  // unsigned magnitude; the most negative code maps to 2^(SW-1)
  assign mag      = softVal[SW-1] ? (~softVal + 1'b1) : softVal;
  assign beyond   = mag > {1'b0, etThresh[TW-1:0]};
  assign aboveNow = allAbove & (~softValid | beyond);
  assign lastIdx  = (idx == lenQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allAbove <= 1'b1;
      lenQ     <= '0;
      idx      <= '0;
      endEvenQ <= 1'b0;
      etPendQ  <= 1'b0;
      halfDone <= '0;
      etPass   <= 1'b0;
    end else begin
      if (strobe.passStart) begin
        allAbove <= 1'b1;
      end else if (softValid && !beyond) begin
        allAbove <= 1'b0;
      end

      if (strobe.accept) begin
        lenQ <= blkLen;
      end

      if (strobe.writeStart) begin
        idx      <= '0;
        endEvenQ <= strobe.endEven;
        etPendQ  <= strobe.etStop;
      end else if (strobe.writing) begin
        idx <= idx + 1'b1;
      end

      if (strobe.finish) begin
        halfDone <= halfCnt;
        etPass   <= etPendQ;
      end else begin
        etPass <= 1'b0;
      end
    end
  end

  assign rdIdx  = idx;
  assign wrCsN  = ~strobe.writing;
  assign wrAddr = endEvenQ ? ilvAddr : idx;
  assign wrBit  = strobe.writing & softVal[SW-1];

endmodule

// File: rtl/turbo_iter_seq.sv
module turbo_iter_seq
  import tis_pkg::*;
#(
  parameter int SW = 8,
  parameter int AW = 15,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          passDone,
  input  logic          softValid,
  input  logic [SW-1:0] softVal,
  input  logic [AW-1:0] blkLen,
  input  logic [CW-1:0] minHalf,
  input  logic [CW-1:0] maxHalf,
  input  logic [SW-2:0] etThresh,
  input  logic [AW-1:0] ilvAddr,
  output logic          busy,
  output logic          ilvOrder,
  output logic [AW-1:0] rdIdx,
  output logic          wrCsN,
  output logic [AW-1:0] wrAddr,
  output logic          wrBit,
  output logic [CW-1:0] halfDone,
  output logic          etPass
);

  seqStrobe_t    strobe;
  logic [CW-1:0] halfCnt;
  logic          aboveNow;
  logic          lastIdx;

  tis_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .passDone  (passDone),
    .aboveNow  (aboveNow),
    .lastIdx   (lastIdx),
    .minHalf   (minHalf),
    .maxHalf   (maxHalf),
    .strobe    (strobe),
    .halfCnt   (halfCnt),
    .busy      (busy),
    .ilvOrder  (ilvOrder)
  );

  tis_dp #(.SW(SW), .AW(AW), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .softValid(softValid),
    .softVal  (softVal),
    .etThresh (etThresh),
    .blkLen   (blkLen),
    .ilvAddr  (ilvAddr),
    .halfCnt  (halfCnt),
    .aboveNow (aboveNow),
    .lastIdx  (lastIdx),
    .rdIdx    (rdIdx),
    .wrCsN    (wrCsN),
    .wrAddr   (wrAddr),
    .wrBit    (wrBit),
    .halfDone (halfDone),
    .etPass   (etPass)
  );

endmodule

// File: rtl/tis_chk.sv
module tis_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          ilvOrder,
  input logic          wrCsN,
  input logic          etPass,
  input logic [CW-1:0] halfDone,
  input logic [CW-1:0] minHalf,
  input logic [CW-1:0] maxHalf
);

  // R7: writes happen only inside a busy block
  p_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrCsN |-> busy);

  // R10: end of the write releases busy in the same cycle
  p_write_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrCsN) |-> !busy);

  // R10: the early-termination flag is a single-cycle pulse
  p_et_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    etPass |=> !etPass);

  // R10: the pulse directly follows a write cycle
  p_et_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(etPass) |-> ($past(!wrCsN) && !busy));

  // R4: a threshold stop never happens below the minimum
  p_et_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    etPass |-> (halfDone >= minHalf));

  // R5: a threshold stop is reported only below the maximum
  p_et_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    etPass |-> (halfDone < maxHalf));

  // R3: order select is low outside a block
  p_order_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ilvOrder);

  // R10: statistics hold while idle
  p_stats_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && !etPass) |-> $stable(halfDone));

endmodule

bind turbo_iter_seq tis_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .ilvOrder(ilvOrder),
  .wrCsN   (wrCsN),
  .etPass  (etPass),
  .halfDone(halfDone),
  .minHalf (minHalf),
  .maxHalf (maxHalf)
);

// File: tb/tb_turbo_iter_seq.sv
module tb_turbo_iter_seq;

  localparam int SW = 8;
  localparam int AW = 15;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          passDone = 1'b0;
  logic          softValid = 1'b0;
  logic [SW-1:0] softVal = '0;
  logic [AW-1:0] blkLen = '0;
  logic [CW-1:0] minHalf = '0;
  logic [CW-1:0] maxHalf = '0;
  logic [SW-2:0] etThresh = '0;
  logic [AW-1:0] ilvAddr = '0;
  logic          busy, ilvOrder, wrCsN, wrBit, etPass;
  logic [AW-1:0] rdIdx, wrAddr;
  logic [CW-1:0] halfDone;

  int nChk = 0;
  int nFail = 0;

  turbo_iter_seq #(.SW(SW), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .passDone(passDone),
    .softValid(softValid), .softVal(softVal), .blkLen(blkLen),
    .minHalf(minHalf), .maxHalf(maxHalf), .etThresh(etThresh),
    .ilvAddr(ilvAddr), .busy(busy), .ilvOrder(ilvOrder), .rdIdx(rdIdx),
    .wrCsN(wrCsN), .wrAddr(wrAddr), .wrBit(wrBit), .halfDone(halfDone),
    .etPass(etPass)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // soft output of pass p, position i
  function automatic int softOf(input int mode, input int p, input int i, input int bl);
    int mag;
    if (mode == 2) return -128;
    mag = 4 * p + (i % 4);
    if (mode == 1 && p == 3 && i == bl - 1) mag = 0;
    return (((i + p) % 3) == 0) ? -mag : mag;
  endfunction

  function automatic int absOf(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int replayOf(input int k);
    return (k * 37 + 11) % 256;
  endfunction

  // one block, expectations derived from the requirements
  task automatic runBlock(input string tag, input int bl, input int minH, input int maxH,
                          input int thr, input int mode, input bit coincide, input bit strayStart);
    int stopP = 0;
    bit expEt = 0;
    for (int p = 1; p <= 31 && stopP == 0; p++) begin
      bit above = 1;
      for (int i = 0; i < bl; i++) if (absOf(softOf(mode, p, i, bl)) <= thr) above = 0;
      if (p >= maxH) stopP = p;
      else if (p >= minH && above) begin stopP = p; expEt = 1; end
    end

    @(negedge clk);
    blkLen = AW'(bl); minHalf = CW'(minH); maxHalf = CW'(maxH);
    etThresh = (SW-1)'(thr); startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    #1 check("R2", {tag, " busy after start"}, int'(busy), 1);

    for (int p = 1; p <= stopP; p++) begin
      for (int i = 0; i < bl; i++) begin
        softValid = 1'b1;
        softVal = SW'(softOf(mode, p, i, bl));
        passDone = coincide && (i == bl - 1);
        if (strayStart && p == 1 && i == 0) startPulse = 1'b1;
        if (i == 0) #1 check("R3", {tag, " order select"}, int'(ilvOrder), (p % 2 == 0) ? 1 : 0);
        @(negedge clk);
        startPulse = 1'b0;
        passDone = 1'b0;
      end
      softValid = 1'b0;
      if (!coincide) begin
        passDone = 1'b1;
        @(negedge clk);
        passDone = 1'b0;
      end
    end

    for (int k = 0; k < bl; k++) begin
      int rv = replayOf(k);
      int ia = (k * 7 + 3) % bl;
      softVal = SW'(rv);
      ilvAddr = AW'(ia);
      #1;
      check("R7", {tag, " chip select"}, int'(wrCsN), 0);
      check("R7", {tag, " index"}, int'(rdIdx), k);
      check("R8", {tag, " write address"}, int'(wrAddr), (stopP % 2 == 0) ? ia : k);
      check("R9", {tag, " hard bit"}, int'(wrBit), (rv >> 7) & 1);
      @(negedge clk);
    end
    #1;
    check("R7", {tag, " chip select released"}, int'(wrCsN), 1);
    check("R10", {tag, " busy cleared"}, int'(busy), 0);
    check("R10", {tag, " half count"}, int'(halfDone), stopP);
    check("R10", {tag, " et pulse"}, int'(etPass), int'(expEt));
    @(negedge clk);
    #1;
    check("R10", {tag, " et pulse ends"}, int'(etPass), 0);
    check("R10", {tag, " count holds"}, int'(halfDone), stopP);
    check("R2", {tag, " no restart from stray start"}, int'(busy), 0);
  endtask

  task automatic testReset();
    #1;
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset chip select", int'(wrCsN), 1);
    check("R1", "reset count", int'(halfDone), 0);
    check("R1", "reset et", int'(etPass), 0);
    check("R1", "reset order", int'(ilvOrder), 0);
  endtask

  task automatic testIdleStrobes();
    @(negedge clk);
    passDone = 1'b1; softValid = 1'b1; softVal = 8'h00;
    @(negedge clk);
    passDone = 1'b0; softValid = 1'b0;
    #1;
    check("R11", "idle passDone busy", int'(busy), 0);
    check("R11", "idle passDone chip select", int'(wrCsN), 1);
    check("R11", "idle passDone count", int'(halfDone), 0);
  endtask

  initial begin
    #(10 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdleStrobes();
    runBlock("R6 early stop odd",     6, 0, 14, 10, 0, 1'b0, 1'b0);
    runBlock("R4 minimum held",       6, 6, 14, 10, 0, 1'b0, 1'b0);
    runBlock("R5 maximum cap",        7, 0, 4, 120, 0, 1'b0, 1'b0);
    runBlock("R5 max below min",      5, 9, 2, 0, 0, 1'b0, 1'b0);
    runBlock("R6 final value counts", 6, 0, 14, 10, 1, 1'b1, 1'b0);
    runBlock("R6 most negative",      5, 1, 14, 126, 2, 1'b0, 1'b1);
    runBlock("R5 zero maximum",       4, 0, 0, 0, 0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule